// File: doc/BRIEF.md
# Five-Wire Serial Control Port

This block is the slave side of a slow serial control link. A host processor uses it to load an 8-bit command word and to fetch a 5-bit status word. The link has five wires: a serial clock, one shared data wire, a direction line, a chip select and a chip-select polarity input. All five are sampled in a much faster system clock domain. The serial clock may run at up to 600 kHz. The shared data wire is presented as three plain ports: incoming data, outgoing data and an output enable. The pad tristate sits outside the block.

When the direction line is low, a select period is a write. Bits are taken on rising serial clock edges, most significant bit first. When the select is released, the word is committed only if exactly eight bits arrived and the direction line stayed low throughout. When the direction line is high, the period is a read. The status input is frozen when the select is asserted and is shifted out most significant bit first. The host may stop after any number of bits up to five.

Committed commands leave on a valid/ready stream. `cmd_valid` rises on a commit and stays high until a cycle with `cmd_ready` high. `cmd_word` holds steady while valid is high and ready is low. A serial write cannot be stalled, so a commit that arrives while the previous word is still pending replaces it and valid stays high. `cmd_word` keeps the last committed word after the handshake, so it also serves as the command register.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, `cmd_word` is 0, `cmd_valid` is 0 and `ser_doe` is 0.
- R2: A write period has the direction line low and exactly 8 rising serial clock edges, first bit = bit 7 of the word. When the select is released, this loads `cmd_word` with the shifted word and raises `cmd_valid`, within 4 system clocks.
- R3: A write period with a rising-edge count other than 8 (for example 7 or 9) leaves `cmd_word` and `cmd_valid` unchanged.
- R4: A write period during which the direction line goes high at any time leaves `cmd_word` and `cmd_valid` unchanged, even if 8 edges arrive.
- R5: `ser_doe` is 1 only inside a read period, which needs the select active and the direction line high. It stays 0 throughout write periods and while the select is idle.
- R6: In a read period, `ser_dout` shows status bit 4 first. It moves to the next lower bit after each falling serial clock edge. The word shown is the value of `status_word` at select assertion, even if `status_word` changes later.
- R7: After five falling edges of a read, `ser_dout` is 0. A read cut short after fewer bits has no side effect: the next read starts again at bit 4.
- R8: When `ser_cs_mode` is 0, the select is active when `ser_cs` is low. When `ser_cs_mode` is 1, it is active when `ser_cs` is high. Writes and reads behave the same under either polarity.
- R9: `cmd_valid` stays 1 until a system clock edge with `cmd_ready` high, which clears it. While it waits, `cmd_word` is stable unless a newer commit replaces it, and that commit keeps `cmd_valid` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_dir | input | 1 | Direction: 0 write into block, 1 read from block |
| ser_cs | input | 1 | Chip select, polarity set by `ser_cs_mode` |
| ser_cs_mode | input | 1 | Select polarity: 0 active low, 1 active high |
| ser_din | input | 1 | Shared data wire, incoming value |
| ser_dout | output | 1 | Shared data wire, outgoing value |
| ser_doe | output | 1 | Output enable for the shared data wire |
| status_word | input | 5 | Parallel status to be read by the host |
| cmd_word | output | 8 | Last committed command word |
| cmd_valid | output | 1 | Stream valid for a newly committed command |
| cmd_ready | input | 1 | Stream ready from the consumer |

## Verification
The checker watches four things on every cycle. The command stream follows the valid/ready rules. `cmd_word` changes only right after a commit that counted exactly eight bits. The output enable never overlaps write shifting. The data wire reads 0 once a read has used up its five bits. Other behaviour depends on stimulus sequences and is shown only by the bench scenarios: discarding short, long or direction-glitched writes, the status snapshot at select assertion, restarting after a shortened read, and the active-high select polarity.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } ctl_phase_e;

  // positions of the pins inside the synchronised vector
  localparam int PIN_DIN  = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_DIR  = 2;
  localparam int PIN_CS   = 3;
  localparam int PIN_MODE = 4;
  localparam int PIN_N    = 5;
endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain <= din[b];
      else chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/ctl_pin_front.sv
module ctl_pin_front
  import ctl_serial_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_dir,
  input  logic       ser_cs,
  input  logic       ser_cs_mode,
  input  logic       ser_din,
  output logic       sclk_rise,
  output logic       sclk_fall,
  output logic       cs_act,
  output logic       cs_start,
  output logic       cs_end,
  output logic       dir_s,
  output logic       din_s,
  output ctl_phase_e phase
);
  localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << PIN_CS;

  logic [PIN_N-1:0] raw, syn;
  logic sclk_d, cs_act_d;

  always_comb begin
    raw = '0;
    raw[PIN_DIN]  = ser_din;
    raw[PIN_SCLK] = ser_clk;
    raw[PIN_DIR]  = ser_dir;
    raw[PIN_CS]   = ser_cs;
    raw[PIN_MODE] = ser_cs_mode;
  end

  ctl_pin_sync #(.W(PIN_N), .STAGES(STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .dout(syn)
  );

  // mode 0: low level selects; mode 1: high level selects
  assign cs_act    = syn[PIN_CS] ^ ~syn[PIN_MODE];
  assign dir_s     = syn[PIN_DIR];
  assign din_s     = syn[PIN_DIN];
  assign sclk_rise = syn[PIN_SCLK] & ~sclk_d;
  assign sclk_fall = ~syn[PIN_SCLK] & sclk_d;
  assign cs_start  = cs_act & ~cs_act_d;
  assign cs_end    = ~cs_act & cs_act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_act_d <= 1'b0;
      phase    <= PH_IDLE;
    end else begin
      sclk_d   <= syn[PIN_SCLK];
      cs_act_d <= cs_act;
      if (cs_start) phase <= dir_s ? PH_READ : PH_WRITE;
      else if (cs_end) phase <= PH_IDLE;
    end
  end
endmodule

// File: rtl/ctl_wr_path.sv
module ctl_wr_path
  import ctl_serial_pkg::*;
#(
  parameter int CMD_W = 8,
  localparam int CNT_W = $clog2(CMD_W + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             cs_act,
  input  logic             cs_start,
  input  logic             cs_end,
  input  logic             dir_s,
  input  logic             din_s,
  input  ctl_phase_e       phase,
  input  logic             cmd_ready,
  output logic [CMD_W-1:0] cmd_word,
  output logic             cmd_valid,
  output logic             commit,
  output logic             wr_shift,
  output logic [CNT_W-1:0] wr_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);

  logic [CMD_W-1:0] shreg;
  logic             dir_bad;
  logic             in_write;

  assign in_write = (phase == PH_WRITE) && cs_act;
  assign wr_shift = in_write && sclk_rise;
  assign commit   = cs_end && (phase == PH_WRITE) && !dir_bad && (wr_cnt == CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      wr_cnt  <= '0;
      dir_bad <= 1'b0;
    end else if (cs_start) begin
      shreg   <= '0;
      wr_cnt  <= '0;
      dir_bad <= 1'b0;
    end else begin
      if (wr_shift) begin
        shreg <= {shreg[CMD_W-2:0], din_s};
        if (wr_cnt != CNT_MAX) wr_cnt <= wr_cnt + 1'b1;
      end
      if (in_write && dir_s) dir_bad <= 1'b1;
    end
  end

  // output stream: latest commit wins, valid held until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
    end else if (commit) begin
      cmd_word  <= shreg;
      cmd_valid <= 1'b1;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_rd_path.sv
module ctl_rd_path
  import ctl_serial_pkg::*;
#(
  parameter int STAT_W = 5,
  localparam int SH_W = $clog2(STAT_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_fall,
  input  logic              cs_act,
  input  logic              cs_start,
  input  logic              dir_s,
  input  ctl_phase_e        phase,
  input  logic [STAT_W-1:0] status_word,
  output logic              ser_dout,
  output logic              ser_doe,
  output logic              rd_done
);
  localparam logic [SH_W-1:0] SH_FULL = SH_W'(STAT_W);

  logic [STAT_W-1:0] snap;
  logic [SH_W-1:0]   shifts;

  assign ser_doe  = (phase == PH_READ) && cs_act && dir_s;
  assign ser_dout = ser_doe && snap[STAT_W-1];
  assign rd_done  = (shifts == SH_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap   <= '0;
      shifts <= '0;
    end else if (cs_start) begin
      snap   <= dir_s ? status_word : '0;
      shifts <= '0;
    end else if (sclk_fall && (phase == PH_READ) && cs_act && !rd_done) begin
      snap   <= {snap[STAT_W-2:0], 1'b0};
      shifts <= shifts + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_serial_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int STAT_W = 5,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(CMD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dir,
  input  logic              ser_cs,
  input  logic              ser_cs_mode,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_doe,
  input  logic [STAT_W-1:0] status_word,
  output logic [CMD_W-1:0]  cmd_word,
  output logic              cmd_valid,
  input  logic              cmd_ready
);
  logic sclk_rise, sclk_fall, cs_act, cs_start, cs_end, dir_s, din_s;
  ctl_phase_e phase;
  logic commit, wr_shift, rd_done;
  logic [CNT_W-1:0] wr_cnt;

  ctl_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n),
    .ser_clk(ser_clk), .ser_dir(ser_dir), .ser_cs(ser_cs),
    .ser_cs_mode(ser_cs_mode), .ser_din(ser_din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_start(cs_start), .cs_end(cs_end), .dir_s(dir_s), .din_s(din_s),
    .phase(phase)
  );

  ctl_wr_path #(.CMD_W(CMD_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise(sclk_rise), .cs_act(cs_act), .cs_start(cs_start),
    .cs_end(cs_end), .dir_s(dir_s), .din_s(din_s), .phase(phase),
    .cmd_ready(cmd_ready), .cmd_word(cmd_word), .cmd_valid(cmd_valid),
    .commit(commit), .wr_shift(wr_shift), .wr_cnt(wr_cnt)
  );

  ctl_rd_path #(.STAT_W(STAT_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .sclk_fall(sclk_fall), .cs_act(cs_act), .cs_start(cs_start),
    .dir_s(dir_s), .phase(phase), .status_word(status_word),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .rd_done(rd_done)
  );
endmodule

// File: rtl/ctl_serial_port_chk.sv
module ctl_serial_port_chk #(
  parameter int CMD_W = 8,
  localparam int CNT_W = $clog2(CMD_W + 2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_dout,
  input logic             ser_doe,
  input logic [CMD_W-1:0] cmd_word,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             commit,
  input logic             wr_shift,
  input logic [CNT_W-1:0] wr_cnt,
  input logic             rd_done
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!cmd_valid && !ser_doe && cmd_word == '0));

  assert_word_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_word) |-> $past(commit));

  assert_word_needs_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_word) |-> ($past(wr_cnt) == CNT_W'(CMD_W)));

  assert_no_drive_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_shift |-> !ser_doe);

  assert_zero_after_five_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_doe && rd_done) |-> !ser_dout);

  assert_valid_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);

  assert_word_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !commit) |=> $stable(cmd_word));

  assert_valid_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !commit) |=> !cmd_valid);
endmodule

bind ctl_serial_port ctl_serial_port_chk #(.CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .ser_doe(ser_doe),
  .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .commit(commit), .wr_shift(wr_shift), .wr_cnt(wr_cnt), .rd_done(rd_done)
);

// File: tb/ctl_serial_port_bench.sv
module ctl_serial_port_bench;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dir = 1'b0, ser_cs = 1'b1, ser_cs_mode = 1'b0, ser_din = 1'b0;
  logic ser_dout, ser_doe;
  logic [4:0] status_word = '0;
  logic [7:0] cmd_word;
  logic cmd_valid;
  logic cmd_ready = 1'b0;

  int total = 0;
  int bad = 0;
  bit oe_in_write;

  always #2 clk = ~clk;

  ctl_serial_port u_ctl_serial_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dir(ser_dir),
    .ser_cs(ser_cs), .ser_cs_mode(ser_cs_mode), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .status_word(status_word),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cs(input bit act);
    ser_cs = ser_cs_mode ? act : ~act;
  endtask

  task automatic ser_write(input logic [15:0] bits, input int n, input bit glitch);
    oe_in_write = 0;
    ser_dir = 1'b0;
    set_cs(1); wait_cyc(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      ser_din = bits[i]; wait_cyc(HALF);
      ser_clk = 1'b1; wait_cyc(HALF);
      ser_clk = 1'b0;
      if (ser_doe) oe_in_write = 1;
      if (glitch && i == n - 4) begin
        ser_dir = 1'b1; wait_cyc(HALF); ser_dir = 1'b0;
      end
    end
    wait_cyc(HALF); set_cs(0); wait_cyc(12);
  endtask

  task automatic ser_read(input int n, input logic [4:0] mid_status, output logic [4:0] got,
                          output bit oe_ok, output logic tail);
    ser_dir = 1'b1; wait_cyc(2);
    set_cs(1); wait_cyc(HALF);
    status_word = mid_status;
    got = '0; oe_ok = 1;
    for (int i = 0; i < n; i++) begin
      if (!ser_doe) oe_ok = 0;
      got[4-i] = ser_dout;
      ser_clk = 1'b1; wait_cyc(HALF);
      ser_clk = 1'b0; wait_cyc(HALF);
    end
    tail = ser_dout;
    set_cs(0); wait_cyc(12);
    ser_dir = 1'b0; wait_cyc(4);
  endtask

  task automatic accept();
    cmd_ready = 1'b1; wait_cyc(1); cmd_ready = 1'b0; wait_cyc(1);
  endtask

  task automatic t_reset();
    chk(cmd_word == 8'h00, "R1", "cmd_word after reset", cmd_word, 0);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(ser_doe == 1'b0, "R1", "ser_doe after reset", ser_doe, 0);
  endtask

  task automatic t_write_basic();
    ser_write(16'h00A5, 8, 0);
    chk(cmd_word == 8'hA5, "R2", "committed word", cmd_word, 8'hA5);
    chk(cmd_valid == 1'b1, "R2", "valid after commit", cmd_valid, 1);
    chk(!oe_in_write, "R5", "oe during write", oe_in_write, 0);
    wait_cyc(30);
    chk(cmd_valid == 1'b1, "R9", "valid held without ready", cmd_valid, 1);
    accept();
    chk(cmd_valid == 1'b0, "R9", "valid cleared by ready", cmd_valid, 0);
    chk(cmd_word == 8'hA5, "R2", "word kept after handshake", cmd_word, 8'hA5);
    ser_write(16'h003C, 8, 0);
    chk(cmd_word == 8'h3C, "R2", "second word", cmd_word, 8'h3C);
    accept();
  endtask

  task automatic t_write_bad_count();
    ser_write(16'h007F, 7, 0);
    chk(cmd_word == 8'h3C && !cmd_valid, "R3", "7-bit write discarded", cmd_word, 8'h3C);
    ser_write(16'h01FF, 9, 0);
    chk(cmd_word == 8'h3C && !cmd_valid, "R3", "9-bit write discarded", cmd_word, 8'h3C);
  endtask

  task automatic t_write_dir_glitch();
    ser_write(16'h00C3, 8, 1);
    chk(cmd_word == 8'h3C && !cmd_valid, "R4", "dir glitch write discarded", cmd_word, 8'h3C);
    chk(!oe_in_write, "R5", "oe during glitched write", oe_in_write, 0);
  endtask

  task automatic t_read_full();
    logic [4:0] got; bit oe_ok; logic tail;
    status_word = 5'b10110;
    wait_cyc(2);
    ser_read(5, 5'b01001, got, oe_ok, tail);
    chk(got == 5'b10110, "R6", "status snapshot msb first", got, 5'b10110);
    chk(oe_ok, "R5", "oe during read", oe_ok, 1);
    chk(tail == 1'b0, "R7", "line after five bits", tail, 0);
    chk(ser_doe == 1'b0, "R5", "oe after release", ser_doe, 0);
  endtask

  task automatic t_read_partial();
    logic [4:0] got; bit oe_ok; logic tail;
    status_word = 5'b11010;
    wait_cyc(2);
    ser_read(3, 5'b11010, got, oe_ok, tail);
    chk(got[4:2] == 3'b110, "R7", "partial read bits", got[4:2], 3'b110);
    ser_read(5, 5'b11010, got, oe_ok, tail);
    chk(got == 5'b11010, "R7", "restart at bit 4", got, 5'b11010);
    chk(cmd_word == 8'h3C && !cmd_valid, "R7", "reads leave command", cmd_word, 8'h3C);
  endtask

  task automatic t_polarity();
    logic [4:0] got; bit oe_ok; logic tail;
    ser_cs_mode = 1'b1; ser_cs = 1'b0; wait_cyc(10);
    chk(ser_doe == 1'b0 && !cmd_valid, "R8", "no event on mode switch", cmd_valid, 0);
    ser_write(16'h005A, 8, 0);
    chk(cmd_word == 8'h5A && cmd_valid, "R8", "active-high write", cmd_word, 8'h5A);
    accept();
    status_word = 5'b00111; wait_cyc(2);
    ser_read(5, 5'b00111, got, oe_ok, tail);
    chk(got == 5'b00111 && oe_ok, "R8", "active-high read", got, 5'b00111);
    ser_cs_mode = 1'b0; ser_cs = 1'b1; wait_cyc(10);
  endtask

  task automatic t_backpressure();
    ser_write(16'h0011, 8, 0);
    ser_write(16'h0099, 8, 0);
    chk(cmd_word == 8'h99 && cmd_valid, "R9", "newer commit replaces pending", cmd_word, 8'h99);
    accept();
    chk(!cmd_valid, "R9", "cleared after replace", cmd_valid, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    t_reset();
    t_write_basic();
    t_write_bad_count();
    t_write_dir_glitch();
    t_read_full();
    t_read_partial();
    t_polarity();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule